// File: doc/BRIEF.md
# Disk Controller Command and Status Register

This block is the command front end of a controller that serves four disk drives. Software reaches it through eight 32-bit registers, chosen by a three-bit register index taken from bus address bits 4:2. The command/status register carries the function code, the drive number, interrupt enable, the done flag, error flags, one attention flag per drive and an interrupt-request flag. Writing that register with done at zero starts a command. The block then does one of three things: it completes the command at once, it flags the drive as missing, or it hands the command to a drive sequencer through a one-cycle per-drive start strobe.

The sequencer moves the data. It reports the end of a command with a one-cycle done pulse and a status word, and the block merges that word into the register. The drive busy, disabled and large-type flags come in as inputs. The bus address, byte count, disk address and multipurpose registers are plain storage that software can read back. Commands are tracked by a small state machine:

- ST_IDLE: no command outstanding. An accepted transfer command moves it to ST_LAUNCH.
- ST_LAUNCH: lasts one cycle and raises the start strobe. It always moves on to ST_WAIT.
- ST_WAIT: waits for the sequencer pulse, which returns it to ST_IDLE. A write to the init register returns every state to ST_IDLE.

Top module: `dkc_ctl`

## Requirements
- R1: Register index 0 is command/status, 1 bus address, 2 byte count, 3 disk address, 4 multipurpose. Indices 5 and 6 read as zero and ignore writes. Index 7 reads as zero. The bus address keeps only its low 18 bits, and bits 31:18 read as zero.
- R2: After reset the command/status register holds only done (bit 7), plus the ready and large bits computed live. Registers 1 to 4 read zero and the interrupt output is low.
- R3: On a read, bit 0 (ready) is 0 when the drive selected by bits 9:8 is busy or disabled and 1 otherwise. Bit 26 is 1 when that drive is of the large type.
- R4: Whenever any error bit is set (incomplete 10, CRC 11, missing memory 13, drive error 14), the summary bit 15 is set as well.
- R5: When the stored bit 31 (master-attention mode) is 1, writing 1 to bit 24 clears the request flag and leaves the attention bits 19:16 alone.
- R6: When the stored bit 31 is 0, writing 1 to bit 24 or to any of bits 19:16 clears bit 24 and all four attention bits.
- R7: Bit 23 is cleared by writing it as 0 and is otherwise kept.
- R8: A write stores bits 3:1 (function), 6 (interrupt enable), 7 (done), 9:8 (drive), 22, 25, 27, 28, 29 and 31. No other stored bit takes the written value.
- R9: A command is accepted only when the written done bit is 0, the written drive is not busy and no command is outstanding. Acceptance clears bits 10, 11, 13, 14 and 15 and drops the interrupt output.
- R10: An accepted command to a disabled drive sets that drive's attention bit (16 plus drive number) and bits 10 and 15, then completes. Otherwise an accepted function 0 (no-op) completes in the same cycle.
- R11: Any other accepted command raises the bit for the written drive on drv_start for exactly the one cycle after the write, with cmd_code showing the function. Done stays 0 until the sequencer pulse.
- R12: Completion sets done (bit 7) and the request flag (bit 24), and ORs in the sequencer status bits 10, 11, 13, 14, 16 to 19 and 23. It then drives the interrupt output to the interrupt enable bit 6.
- R13: The interrupt output is a held level. A register write with any of bits 19:16 at 1 drops it.
- R14: A write to index 7 returns all registers, the state machine and the interrupt output to the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index (bus address bits 4:2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for reg_idx, combinational |
| drv_busy | input | 4 | Per-drive busy flags |
| drv_off | input | 4 | Per-drive disabled flags |
| drv_large | input | 4 | Per-drive large-type flags |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_stat | input | 32 | Status bits merged at completion |
| drv_start | output | 4 | One-cycle per-drive start strobe |
| cmd_code | output | 3 | Stored function code |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the block with the default 18-bit address width. Random 32-bit words written to the bus address register therefore always carry upper bits that must read back as zero. The fixed four-drive layout lets the bench give each drive its own busy, disabled and large flag, so a single run covers every dispatch path and both attention-clear modes. Random command/status writes with done held at 1 exercise the clear and store rules against a bench model, without starting commands.

// File: rtl/dkc_pkg.sv
`timescale 1ns/1ps
package dkc_pkg;
    localparam int DRIVES = 4;
    localparam int DSEL_W = $clog2(DRIVES);
    localparam int CSR_W  = 32;
    localparam int FUNC_W = 3;

    localparam int P_FUNC  = 1;
    localparam int P_IE    = 6;
    localparam int P_DONE  = 7;
    localparam int P_DSEL  = 8;
    localparam int P_ESUM  = 15;
    localparam int P_ATN   = 16;
    localparam int P_SSE   = 23;
    localparam int P_IRQ   = 24;
    localparam int P_LARGE = 26;
    localparam int P_MATN  = 31;

    localparam logic [CSR_W-1:0] M_WRITE   = 32'hBA40_03CE;
    localparam logic [CSR_W-1:0] M_ERR     = 32'h0000_6C00;
    localparam logic [CSR_W-1:0] M_ERR_ALL = 32'h0000_EC00;
    localparam logic [CSR_W-1:0] M_INC_ERR = 32'h0000_8400;
    localparam logic [CSR_W-1:0] M_STAT    = 32'h008F_6C00;
    localparam logic [CSR_W-1:0] CSR_RST   = 32'h0000_0080;

    localparam logic [2:0] RI_CSR   = 3'd0;
    localparam logic [2:0] RI_BADDR = 3'd1;
    localparam logic [2:0] RI_BCNT  = 3'd2;
    localparam logic [2:0] RI_INIT  = 3'd7;

    localparam logic [FUNC_W-1:0] FN_NOP = 3'd0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT
    } cmd_state_t;
endpackage

// File: rtl/dkc_aux_regs.sv
`timescale 1ns/1ps
module dkc_aux_regs
    import dkc_pkg::*;
#(
    parameter int ADDR_KEEP = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_init,
    input  logic                 bus_we,
    input  logic [2:0]           reg_idx,
    input  logic [CSR_W-1:0]     wdata,
    output logic [ADDR_KEEP-1:0] ba_q,
    output logic [CSR_W-1:0]     bc_q,
    output logic [CSR_W-1:0]     da_q,
    output logic [CSR_W-1:0]     mp_q
);
    localparam int N_FULL = 3;

    logic [CSR_W-1:0] full_q [N_FULL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ba_q <= '0;
        end else if (soft_init) begin
            ba_q <= '0;
        end else if (bus_we && reg_idx == RI_BADDR) begin
            ba_q <= wdata[ADDR_KEEP-1:0];
        end
    end

    for (genvar gi = 0; gi < N_FULL; gi++) begin : g_full
        localparam logic [2:0] MY_IDX = RI_BCNT + 3'(gi);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                full_q[gi] <= '0;
            end else if (soft_init) begin
                full_q[gi] <= '0;
            end else if (bus_we && reg_idx == MY_IDX) begin
                full_q[gi] <= wdata;
            end
        end
    end

    assign bc_q = full_q[0];
    assign da_q = full_q[1];
    assign mp_q = full_q[2];
endmodule

// File: rtl/dkc_cmd_fsm.sv
`timescale 1ns/1ps
module dkc_cmd_fsm
    import dkc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_init,
    input  logic              launch_req,
    input  logic [DSEL_W-1:0] launch_drv,
    input  logic              seq_done,
    output logic              fsm_idle,
    output logic              seq_fin,
    output logic [DRIVES-1:0] drv_start
);
    cmd_state_t        state, nxt;
    logic [DSEL_W-1:0] drv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (soft_init) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '0;
        end else if (launch_req) begin
            drv_q <= launch_drv;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = launch_req ? ST_LAUNCH : ST_IDLE;
            ST_LAUNCH: nxt = ST_WAIT;
            ST_WAIT:   nxt = seq_done ? ST_IDLE : ST_WAIT;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        fsm_idle = (state == ST_IDLE);
        seq_fin  = (state == ST_WAIT) && seq_done;
    end

    for (genvar gd = 0; gd < DRIVES; gd++) begin : g_strobe
        assign drv_start[gd] = (state == ST_LAUNCH) && (drv_q == DSEL_W'(gd));
    end
endmodule

// File: rtl/dkc_csr.sv
`timescale 1ns/1ps
module dkc_csr
    import dkc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_init,
    input  logic              we_csr,
    input  logic [CSR_W-1:0]  wdata,
    input  logic [DRIVES-1:0] drv_busy,
    input  logic [DRIVES-1:0] drv_off,
    input  logic              fsm_idle,
    input  logic              seq_fin,
    input  logic [CSR_W-1:0]  seq_stat,
    output logic [CSR_W-1:0]  csr_q,
    output logic              irq,
    output logic              launch_req,
    output logic [DSEL_W-1:0] launch_drv
);
    logic [CSR_W-1:0]  n;
    logic              irq_n;
    logic              fin;
    logic [DSEL_W-1:0] wsel;
    logic [FUNC_W-1:0] wfunc;

    assign wsel       = wdata[P_DSEL +: DSEL_W];
    assign wfunc      = wdata[P_FUNC +: FUNC_W];
    assign launch_drv = wsel;

    always_comb begin
        n          = csr_q;
        irq_n      = irq;
        fin        = 1'b0;
        launch_req = 1'b0;
        if (we_csr) begin
            // clear rules use the mode bit held before this write
            if (csr_q[P_MATN]) begin
                if (wdata[P_IRQ]) begin
                    n[P_IRQ] = 1'b0;
                end
            end else if (wdata[P_IRQ] || (|wdata[P_ATN +: DRIVES])) begin
                n[P_IRQ]           = 1'b0;
                n[P_ATN +: DRIVES] = '0;
            end
            if (!wdata[P_SSE]) begin
                n[P_SSE] = 1'b0;
            end
            n = (n & ~M_WRITE) | (wdata & M_WRITE);
            if (|wdata[P_ATN +: DRIVES]) begin
                irq_n = 1'b0;
            end
            if (!wdata[P_DONE] && !drv_busy[wsel] && fsm_idle) begin
                irq_n = 1'b0;
                n     = n & ~M_ERR_ALL;
                if (drv_off[wsel]) begin
                    n[P_ATN + int'(wsel)] = 1'b1;
                    n   = n | M_INC_ERR;
                    fin = 1'b1;
                end else if (wfunc == FN_NOP) begin
                    fin = 1'b1;
                end else begin
                    launch_req = 1'b1;
                end
            end
        end
        if (seq_fin) begin
            n   = n | (seq_stat & M_STAT);
            fin = 1'b1;
        end
        if (fin) begin
            n[P_DONE] = 1'b1;
            n[P_IRQ]  = 1'b1;
            irq_n     = n[P_IE];
        end
        if (|(n & M_ERR)) begin
            n[P_ESUM] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= CSR_RST;
            irq   <= 1'b0;
        end else if (soft_init) begin
            csr_q <= CSR_RST;
            irq   <= 1'b0;
        end else begin
            csr_q <= n;
            irq   <= irq_n;
        end
    end
endmodule

// File: rtl/dkc_ctl.sv
`timescale 1ns/1ps
module dkc_ctl
    import dkc_pkg::*;
#(
    parameter int ADDR_KEEP = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [2:0]        reg_idx,
    input  logic [CSR_W-1:0]  wdata,
    output logic [CSR_W-1:0]  rdata,
    input  logic [DRIVES-1:0] drv_busy,
    input  logic [DRIVES-1:0] drv_off,
    input  logic [DRIVES-1:0] drv_large,
    input  logic              seq_done,
    input  logic [CSR_W-1:0]  seq_stat,
    output logic [DRIVES-1:0] drv_start,
    output logic [2:0]        cmd_code,
    output logic              irq
);
    logic                 soft_init;
    logic                 we_csr;
    logic [CSR_W-1:0]     csr_q;
    logic [CSR_W-1:0]     csr_view;
    logic [DSEL_W-1:0]    cur_sel;
    logic                 fsm_idle;
    logic                 seq_fin;
    logic                 launch_req;
    logic [DSEL_W-1:0]    launch_drv;
    logic [ADDR_KEEP-1:0] ba_q;
    logic [CSR_W-1:0]     bc_q, da_q, mp_q;

    assign soft_init = bus_we && (reg_idx == RI_INIT);
    assign we_csr    = bus_we && (reg_idx == RI_CSR);

    dkc_aux_regs #(.ADDR_KEEP(ADDR_KEEP)) u_aux (
        .clk(clk), .rst_n(rst_n), .soft_init(soft_init), .bus_we(bus_we),
        .reg_idx(reg_idx), .wdata(wdata),
        .ba_q(ba_q), .bc_q(bc_q), .da_q(da_q), .mp_q(mp_q)
    );

    dkc_csr u_csr (
        .clk(clk), .rst_n(rst_n), .soft_init(soft_init), .we_csr(we_csr),
        .wdata(wdata), .drv_busy(drv_busy), .drv_off(drv_off),
        .fsm_idle(fsm_idle), .seq_fin(seq_fin), .seq_stat(seq_stat),
        .csr_q(csr_q), .irq(irq), .launch_req(launch_req), .launch_drv(launch_drv)
    );

    dkc_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .soft_init(soft_init),
        .launch_req(launch_req), .launch_drv(launch_drv), .seq_done(seq_done),
        .fsm_idle(fsm_idle), .seq_fin(seq_fin), .drv_start(drv_start)
    );

    assign cur_sel  = csr_q[P_DSEL +: DSEL_W];
    assign cmd_code = csr_q[P_FUNC +: FUNC_W];

    always_comb begin
        csr_view          = csr_q;
        csr_view[0]       = !(drv_busy[cur_sel] || drv_off[cur_sel]);
        csr_view[P_LARGE] = drv_large[cur_sel];
    end

    always_comb begin
        case (reg_idx)
            3'd0:    rdata = csr_view;
            3'd1:    rdata = {{(CSR_W-ADDR_KEEP){1'b0}}, ba_q};
            3'd2:    rdata = bc_q;
            3'd3:    rdata = da_q;
            3'd4:    rdata = mp_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/dkc_ctl_chk.sv
`timescale 1ns/1ps
module dkc_ctl_chk
    import dkc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [2:0]        reg_idx,
    input logic [CSR_W-1:0]  wdata,
    input logic [CSR_W-1:0]  rdata,
    input logic [DRIVES-1:0] drv_busy,
    input logic              seq_done,
    input logic [DRIVES-1:0] drv_start,
    input logic              irq,
    input logic [CSR_W-1:0]  csr_q
);
    assert_ba_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx == RI_BADDR) |-> (rdata[CSR_W-1:18] == '0));

    assert_err_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(csr_q & M_ERR)) |-> csr_q[P_ESUM]);

    assert_start_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|drv_start) |-> $past(bus_we && reg_idx == RI_CSR && !wdata[P_DONE]));

    assert_start_idle_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|drv_start) |-> $past(!drv_busy[wdata[P_DSEL +: DSEL_W]]));

    assert_start_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_start));

    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|drv_start) |=> (drv_start == '0));

    assert_irq_needs_ie_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> csr_q[P_IE]);

    assert_attn_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && reg_idx == RI_CSR && (|wdata[P_ATN +: DRIVES]) && wdata[P_DONE] && !seq_done)
        |=> !irq);

    assert_init_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && reg_idx == RI_INIT) |=> (!irq && csr_q == CSR_RST));
endmodule

bind dkc_ctl dkc_ctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .reg_idx(reg_idx),
    .wdata(wdata), .rdata(rdata), .drv_busy(drv_busy), .seq_done(seq_done),
    .drv_start(drv_start), .irq(irq), .csr_q(csr_q)
);

// File: tb/sim_dkc_ctl.sv
`timescale 1ns/1ps
module sim_dkc_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  drv_busy = '0, drv_off = '0, drv_large = 4'b0001;
    logic        seq_done = 1'b0;
    logic [31:0] seq_stat = '0;
    logic [3:0]  drv_start;
    logic [2:0]  cmd_code;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    localparam logic [31:0] WMASK = 32'hBA40_03CE;
    localparam logic [31:0] LIVE  = 32'h0400_0001;

    dkc_ctl u0 (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; reg_idx = i; wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] i, output logic [31:0] v);
        reg_idx = i;
        #1;
        v = rdata;
    endtask

    task automatic finish_cmd(input logic [31:0] st);
        @(negedge clk);
        seq_done = 1'b1; seq_stat = st;
        @(negedge clk);
        seq_done = 1'b0; seq_stat = '0;
    endtask

    function automatic logic [31:0] aux_exp(input logic [2:0] i, input logic [31:0] d);
        if (i == 3'd1) return d & 32'h0003_FFFF;
        if (i >= 3'd2 && i <= 3'd4) return d;
        return 32'h0;
    endfunction

    function automatic logic [31:0] csr_model(input logic [31:0] old, input logic [31:0] wd);
        logic [31:0] nv;
        nv = old & ~LIVE;
        if (old[31]) begin
            if (wd[24]) nv[24] = 1'b0;
        end else if (wd[24] || wd[19:16] != 4'h0) begin
            nv[24] = 1'b0;
            nv[19:16] = 4'h0;
        end
        if (!wd[23]) nv[23] = 1'b0;
        nv = (nv & ~WMASK) | (wd & WMASK);
        return nv;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, old, wd, sd;
        logic        irq_b;
        v = $urandom(32'd7341);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 R3: reset view, drive 0 large and ready
        @(negedge clk);
        rd(3'd0, v); chk("R2 csr reset", v, 32'h0400_0081);
        for (int i = 1; i <= 4; i++) begin
            rd(3'(i), v); chk("R2 reg reset", v, 32'h0);
        end
        chk("R2 irq reset", {31'b0, irq}, 32'h0);

        // R1: random register traffic
        for (int k = 0; k < 24; k++) begin
            logic [2:0] ix;
            ix = 3'($urandom_range(1, 6));
            wd = $urandom;
            wr(ix, wd);
            rd(ix, v); chk("R1 register readback", v, aux_exp(ix, wd));
        end
        rd(3'd7, v); chk("R1 init reads zero", v, 32'h0);

        // R3: ready and large follow selected drive
        drv_busy = 4'b0100;
        wr(3'd0, 32'h0000_0284);
        rd(3'd0, v); chk("R3 busy drive not ready", v, 32'h0000_0284);
        drv_busy = 4'b0000;
        rd(3'd0, v); chk("R3 idle drive ready", v, 32'h0000_0285);
        drv_large = 4'b0101;
        rd(3'd0, v); chk("R3 large drive", v, 32'h0400_0285);
        drv_large = 4'b0001;

        // R10: start on disabled drive 3
        drv_off = 4'b1000;
        wr(3'd0, 32'h0000_034C);
        chk("R10 no strobe for disabled", {28'b0, drv_start}, 32'h0);
        rd(3'd0, v); chk("R10 disabled completion", v, 32'h0108_87CC);
        chk("R12 irq with IE", {31'b0, irq}, 32'h1);

        // R5: master-attention mode
        wr(3'd0, 32'h8000_0380);
        rd(3'd0, v); chk("R8 mode bit stored", v, 32'h8108_8780);
        chk("R13 irq held", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h8100_0380);
        rd(3'd0, v); chk("R5 request cleared, attention kept", v, 32'h8008_8780);
        wr(3'd0, 32'h8001_0380);
        rd(3'd0, v); chk("R5 attention write ignored in mode", v, 32'h8008_8780);
        chk("R13 attention write drops irq", {31'b0, irq}, 32'h0);

        // R6: plain mode clears all attention
        wr(3'd0, 32'h0000_0380);
        wr(3'd0, 32'h0000_030C);
        rd(3'd0, v); chk("R10 disabled completion IE off", v, 32'h0108_878C);
        chk("R12 no irq without IE", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'h0002_0380);
        rd(3'd0, v); chk("R6 attention and request cleared", v, 32'h0000_8780);

        // R5 R6 R7 R8: random writes with done held at 1
        for (int k = 0; k < 40; k++) begin
            if ($urandom_range(0, 1) == 1) begin
                sd = 32'h0000_0300 | {28'b0, 3'($urandom_range(0, 7)), 1'b0}
                   | ($urandom_range(0, 1) ? 32'h40 : 32'h0)
                   | ($urandom_range(0, 1) ? 32'h8000_0000 : 32'h0);
                wr(3'd0, sd);
            end
            rd(3'd0, old);
            irq_b = irq;
            wd = $urandom | 32'h80;
            wr(3'd0, wd);
            rd(3'd0, v);
            chk("R8 random csr write (R5 R6 R7)", v & ~LIVE, csr_model(old, wd));
            chk("R13 random irq level", {31'b0, irq}, {31'b0, irq_b && wd[19:16] == 4'h0});
        end
        drv_off = 4'b0000;

        // R9 R10: no-op start
        wr(3'd0, 32'h0000_0080);
        wr(3'd0, 32'h010F_0080);
        wr(3'd0, 32'h0000_0040);
        rd(3'd0, v); chk("R10 no-op completes, R9 errors cleared", v, 32'h0500_00C1);
        chk("R12 no-op irq", {31'b0, irq}, 32'h1);

        // R9: busy drive ignores start
        drv_busy = 4'b0010;
        wr(3'd0, 32'h0000_010C);
        chk("R9 busy drive no strobe", {28'b0, drv_start}, 32'h0);
        rd(3'd0, v); chk("R9 busy drive no start", v, 32'h0100_010C);
        @(negedge clk);
        chk("R9 busy drive still no strobe", {28'b0, drv_start}, 32'h0);
        chk("R9 irq kept", {31'b0, irq}, 32'h1);
        drv_busy = 4'b0000;

        // R11: launch read on drive 2
        wr(3'd0, 32'h0000_024C);
        chk("R11 strobe drive 2", {28'b0, drv_start}, 32'h4);
        chk("R11 function code", {29'b0, cmd_code}, 32'h6);
        chk("R9 start drops irq", {31'b0, irq}, 32'h0);
        rd(3'd0, v); chk("R11 done clear while running", v, 32'h0100_024D);
        @(negedge clk);
        chk("R11 strobe one cycle", {28'b0, drv_start}, 32'h0);
        wr(3'd0, 32'h0000_034C);
        chk("R9 outstanding blocks start", {28'b0, drv_start}, 32'h0);
        finish_cmd(32'h0084_0800 | 32'h0400_0001);
        rd(3'd0, v); chk("R12 completion merge, R4 summary", v, 32'h0184_8BCD);
        chk("R12 irq with IE", {31'b0, irq}, 32'h1);

        // R7: bit 23 kept by a one, cleared by a zero
        wr(3'd0, 32'h0080_00C0);
        rd(3'd0, v); chk("R7 bit 23 kept", v, 32'h0584_88C1);
        wr(3'd0, 32'h0000_00C0);
        rd(3'd0, v); chk("R7 bit 23 cleared", v, 32'h0504_88C1);

        // R12: completion with IE clear
        wr(3'd0, 32'h0000_020C);
        chk("R11 strobe drive 2 again", {28'b0, drv_start}, 32'h4);
        finish_cmd(32'h0000_2000);
        rd(3'd0, v); chk("R12 completion IE off", v, 32'h0104_A28D);
        chk("R12 no irq IE off", {31'b0, irq}, 32'h0);

        // R14: init
        wr(3'd0, 32'h0000_0040);
        wr(3'd1, 32'h0003_FFFF);
        wr(3'd7, 32'h0);
        rd(3'd0, v); chk("R14 csr after init", v, 32'h0400_0081);
        rd(3'd1, v); chk("R14 address after init", v, 32'h0);
        chk("R14 irq after init", {31'b0, irq}, 32'h0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule